// File: doc/BRIEF.md
# Euclidean GCD Engine

This block finds the greatest common divisor of two nonzero unsigned operands using Euclid's method. A rising edge on `start` while the engine is idle captures both operand buses into two working registers. If the operands are equal, the engine publishes that value at once. Otherwise it arranges the registers so the larger value sits in the first one. It then repeats three steps: take the remainder of the first register by the second, write the remainder back into the first register, and exchange the two registers if the remainder is not zero. When a remainder of zero appears, the second register holds the answer.

A Moore controller sequences a small datapath. The datapath holds the two working registers, the published result and the `ready` flag. The remainder comes from a serial shift-subtract unit that settles one quotient bit per clock, so no divider array is needed. The result and `ready` stay as they are until the next accepted start. Start edges that arrive while a computation is running are ignored.

Top module: `gcd_engine`

## Requirements
- R1: While synchronous reset is high, and after it is released with no start, `ready` is 0 and `result` is 0.
- R2: When the engine is idle, a 0-to-1 change of `start` seen at a clock edge is accepted and captures `op_a` and `op_b`. From the second clock edge after acceptance, `ready` reads 0 until the new result is published.
- R3: For unequal operands, `result` equals the greatest common divisor of the captured operands when `ready` rises. For example, operands 15 and 24 give 3.
- R4: For equal operands, `result` equals the operand value, and `ready` reads 1 right after the third clock edge that follows the edge of acceptance.
- R5: The order of the operands has no effect on the result. With `op_a` smaller than `op_b`, the result matches the one for the swapped pair.
- R6: Start edges that arrive while a computation is in progress, including in the cycle that publishes the result, are ignored. The result is still correct and no second computation follows.
- R7: After publication, `ready` stays 1 and `result` keeps its value while `start` stays low, even if the operand buses change.
- R8: Only a rising edge starts work. Holding `start` high after publication starts nothing: `ready` stays 1 and `result` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request; a rising edge while idle begins a computation |
| op_a | input | WIDTH | First operand, nonzero |
| op_b | input | WIDTH | Second operand, nonzero |
| result | output | WIDTH | Greatest common divisor of the last completed computation |
| ready | output | 1 | High once a result is published, low while computing |

## Verification
Two events can land in the same cycle: a new start edge and the last step of a computation, the one that publishes the result. To provoke this, the bench toggles `start` every cycle during each run, with two different phase offsets, so that over many operand pairs an edge falls on the publishing cycle and on every other busy state. The bench judges the outcome by three things. The published value must equal an arithmetic GCD computed in the bench. `ready` must stay high. The result must not change afterwards, which shows that no stray second computation was launched.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

    localparam int unsigned GCD_DEFAULT_WIDTH = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOAD,
        S_CHECK,
        S_SWAP,
        S_REM_START,
        S_REM_WAIT,
        S_STORE,
        S_TEST,
        S_XCHG,
        S_DONE
    } gcd_state_e;

    // Moore control word: one bit per datapath micro-operation
    typedef struct packed {
        logic load;     // capture operands, drop ready
        logic swap;     // exchange working registers
        logic rem_go;   // launch remainder unit
        logic store;    // write remainder into first register
        logic publish;  // drive result, raise ready
    } gcd_ctl_t;

    // Status returned by the datapath
    typedef struct packed {
        logic equal;
        logic less;
        logic zero;
    } gcd_flags_t;

    function automatic gcd_ctl_t decode_state(gcd_state_e s);
        gcd_ctl_t c;
        c = '0;
        unique case (s)
            S_LOAD:      c.load    = 1'b1;
            S_SWAP:      c.swap    = 1'b1;
            S_XCHG:      c.swap    = 1'b1;
            S_REM_START: c.rem_go  = 1'b1;
            S_STORE:     c.store   = 1'b1;
            S_DONE:      c.publish = 1'b1;
            default:     c = '0;
        endcase
        return c;
    endfunction

    function automatic logic is_busy(gcd_state_e s);
        return (s != S_IDLE);
    endfunction

endpackage

// File: rtl/gcd_start_sense.sv
module gcd_start_sense (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic start_rise
);
    logic start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
        end else begin
            start_q <= start;
        end
    end

    assign start_rise = start & ~start_q;
endmodule

// File: rtl/gcd_remainder.sv
module gcd_remainder #(
    parameter int unsigned WIDTH = gcd_pkg::GCD_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             done,
    output logic [WIDTH-1:0] remainder
);
    localparam int unsigned CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] STEPS = CW'(WIDTH);

    logic             busy;
    logic [CW-1:0]    steps_left;
    logic [WIDTH:0]   partial;
    logic [WIDTH-1:0] bits_in;
    logic [WIDTH:0]   trial;
    logic [WIDTH:0]   diff;

    // Shift in the next dividend bit, then try subtracting the divisor
    assign trial = {partial[WIDTH-1:0], bits_in[WIDTH-1]};
    assign diff  = trial - {1'b0, divisor};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            steps_left <= '0;
            partial    <= '0;
            bits_in    <= '0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                busy       <= 1'b1;
                steps_left <= STEPS;
                partial    <= '0;
                bits_in    <= dividend;
            end else if (busy) begin
                partial    <= diff[WIDTH] ? trial : diff;
                bits_in    <= {bits_in[WIDTH-2:0], 1'b0};
                steps_left <= steps_left - 1'b1;
                if (steps_left == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign remainder = partial[WIDTH-1:0];
endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
    import gcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_rise,
    input  gcd_flags_t flags,
    input  logic       rem_done,
    output gcd_state_e state,
    output gcd_ctl_t   ctl
);
    gcd_state_e next_state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
        end else begin
            state <= next_state;
        end
    end

    always_comb begin
        next_state = state;
        unique case (state)
            S_IDLE:      if (start_rise) next_state = S_LOAD;
            S_LOAD:      next_state = S_CHECK;
            S_CHECK: begin
                if (flags.equal)     next_state = S_DONE;
                else if (flags.less) next_state = S_SWAP;
                else                 next_state = S_REM_START;
            end
            S_SWAP:      next_state = S_REM_START;
            S_REM_START: next_state = S_REM_WAIT;
            S_REM_WAIT:  if (rem_done) next_state = S_STORE;
            S_STORE:     next_state = S_TEST;
            S_TEST:      next_state = flags.zero ? S_DONE : S_XCHG;
            S_XCHG:      next_state = S_REM_START;
            S_DONE:      next_state = S_IDLE;
            default:     next_state = S_IDLE;
        endcase
    end

    // Moore outputs: a function of the state alone
    assign ctl = decode_state(state);
endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
    import gcd_pkg::*;
#(
    parameter int unsigned WIDTH = GCD_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  gcd_ctl_t         ctl,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] rem_value,
    output logic [WIDTH-1:0] big_q,
    output logic [WIDTH-1:0] small_q,
    output logic [WIDTH-1:0] result,
    output logic             ready,
    output gcd_flags_t       flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            big_q   <= '0;
            small_q <= '0;
            result  <= '0;
            ready   <= 1'b0;
        end else begin
            if (ctl.load) begin
                big_q   <= op_a;
                small_q <= op_b;
                ready   <= 1'b0;
            end
            if (ctl.swap) begin
                big_q   <= small_q;
                small_q <= big_q;
            end
            if (ctl.store) begin
                big_q <= rem_value;
            end
            if (ctl.publish) begin
                result <= small_q;
                ready  <= 1'b1;
            end
        end
    end

    always_comb begin
        flags.equal = (big_q == small_q);
        flags.less  = (big_q < small_q);
        flags.zero  = (big_q == '0);
    end
endmodule

// File: rtl/gcd_engine.sv
module gcd_engine
    import gcd_pkg::*;
#(
    parameter int unsigned WIDTH = GCD_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] result,
    output logic             ready
);
    logic             start_rise;
    gcd_state_e       state;
    gcd_ctl_t         ctl;
    gcd_flags_t       flags;
    logic [WIDTH-1:0] big_q;
    logic [WIDTH-1:0] small_q;
    logic             rem_done;
    logic [WIDTH-1:0] rem_value;

    gcd_start_sense u_sense (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_rise (start_rise)
    );

    gcd_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_rise (start_rise),
        .flags      (flags),
        .rem_done   (rem_done),
        .state      (state),
        .ctl        (ctl)
    );

    gcd_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .op_a      (op_a),
        .op_b      (op_b),
        .rem_value (rem_value),
        .big_q     (big_q),
        .small_q   (small_q),
        .result    (result),
        .ready     (ready),
        .flags     (flags)
    );

    gcd_remainder #(.WIDTH(WIDTH)) u_rem (
        .clk       (clk),
        .rst       (rst),
        .go        (ctl.rem_go),
        .dividend  (big_q),
        .divisor   (small_q),
        .done      (rem_done),
        .remainder (rem_value)
    );
endmodule

// File: rtl/gcd_engine_checker.sv
module gcd_engine_checker
    import gcd_pkg::*;
#(
    parameter int unsigned WIDTH = GCD_DEFAULT_WIDTH
) (
    input logic             clk,
    input logic             rst,
    input gcd_state_e       state,
    input logic [WIDTH-1:0] big_q,
    input logic [WIDTH-1:0] small_q,
    input logic             rem_done,
    input logic [WIDTH-1:0] rem_value,
    input logic [WIDTH-1:0] result,
    input logic             ready
);
    assert_ready_clear_on_load_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_LOAD) |=> !ready);

    assert_ready_only_from_done_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> ($past(state) == S_DONE));

    assert_rem_below_divisor_R3: assert property (@(posedge clk) disable iff (rst)
        rem_done |-> (rem_value < small_q));

    assert_equal_short_path_R4: assert property (@(posedge clk) disable iff (rst)
        (state == S_CHECK && big_q == small_q) |=> (state == S_DONE));

    assert_larger_first_R5: assert property (@(posedge clk) disable iff (rst)
        (state == S_REM_START) |-> (big_q >= small_q));

    assert_busy_no_reload_R6: assert property (@(posedge clk) disable iff (rst)
        (state != S_IDLE) |=> (state != S_LOAD));

    assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (state != S_DONE) |=> $stable(result));
endmodule

bind gcd_engine gcd_engine_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .big_q     (big_q),
    .small_q   (small_q),
    .rem_done  (rem_done),
    .rem_value (rem_value),
    .result    (result),
    .ready     (ready)
);

// File: tb/gcd_engine_bench.sv
module gcd_engine_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] result;
    logic         ready;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    gcd_engine #(.WIDTH(W)) u_gcd_engine (
        .clk(clk), .rst(rst), .start(start),
        .op_a(op_a), .op_b(op_b), .result(result), .ready(ready)
    );

    function automatic int ref_gcd(int a, int b);
        int t;
        while (b != 0) begin
            t = a % b;
            a = b;
            b = t;
        end
        return a;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // mode 0: start held high; 1/2: start toggled while busy with two phases
    task automatic run_pair(input int a, input int b, input int mode,
                            output int res, output int cyc);
        op_a = W'(a);
        op_b = W'(b);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cyc = 2;
        check("R2", "ready low after accept", int'(ready), 0);
        while (!ready && cyc < 3000) begin
            if (mode != 0 && cyc >= mode + 1) start = ~start;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        res = int'(result);
    endtask

    task automatic judge(input int a, input int b, input int mode);
        int res, cyc, exp;
        run_pair(a, b, mode, res, cyc);
        exp = ref_gcd(a, b);
        if (a == b) begin
            check("R4", "equal operand result", res, a);
            check("R4", "equal operand latency", cyc, 4);
        end else if (a < b) begin
            check("R5", "reversed order result", res, exp);
        end else begin
            check("R3", "gcd result", res, exp);
        end
        if (mode != 0) check("R6", "result with busy start edges", res, exp);
    endtask

    initial begin
        int res, cyc, hold;
        repeat (3) @(negedge clk);
        check("R1", "ready in reset", int'(ready), 0);
        check("R1", "result in reset", int'(result), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "ready after reset", int'(ready), 0);
        check("R1", "result after reset", int'(result), 0);

        run_pair(15, 24, 0, res, cyc);
        check("R3", "15 and 24", res, 3);
        run_pair(24, 15, 0, res, cyc);
        check("R3", "24 and 15", res, 3);

        // R7: hold with start low, operand buses changing
        hold = res;
        for (int i = 0; i < 20; i++) begin
            op_a = W'(i * 7 + 1);
            op_b = W'(i * 3 + 2);
            @(negedge clk);
        end
        check("R7", "ready held", int'(ready), 1);
        check("R7", "result held", int'(result), hold);

        // R8: start held high after completion
        run_pair(200, 75, 0, res, cyc);
        check("R3", "200 and 75", res, 25);
        start = 1'b1;
        op_a = 8'd9;
        op_b = 8'd6;
        repeat (30) @(negedge clk);
        check("R8", "ready while start held", int'(ready), 1);
        check("R8", "result while start held", int'(result), 25);
        start = 1'b0;
        @(negedge clk);

        judge(255, 255, 0);
        judge(1, 1, 1);
        judge(255, 1, 0);
        judge(1, 255, 2);
        judge(255, 254, 1);
        judge(233, 144, 0);
        judge(144, 233, 2);
        judge(128, 96, 1);
        judge(96, 128, 0);

        for (int a = 1; a <= 20; a++) begin
            for (int b = 1; b <= 20; b++) begin
                judge(a, b, (a + b) % 3);
            end
        end

        // R6 and R7: no stray computation after toggled runs
        run_pair(91, 35, 1, res, cyc);
        check("R6", "91 and 35 toggled", res, 7);
        repeat (40) @(negedge clk);
        check("R6", "no second run ready", int'(ready), 1);
        check("R6", "no second run result", int'(result), 7);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule